// File: doc/BRIEF.md
# Peripheral Pin Multiplexer Port

This block sits between a set of package pins and the on-chip peripherals (UART, printer, scanner, DMA) that may share them. Software writes a data word for the output pins. Software also writes a per-pin select word. The select word decides, pin by pin, whether the pin carries the software bit or the signal of the peripheral assigned to it. One global enable bit turns all output drivers on or off together. The pins come out of reset tri-stated and in software mode.

On the input side, every pin passes through a synchronizer before software can read it or a peripheral can use it. Two input pins feed the UART: a transmit-enable line and a receive-data line. Each has its own select bit. While a select bit is clear, the UART sees a fixed safe level instead of the pin. The transmit-enable line is held low and the receive line is held at its idle-high level.

Access is through a simple synchronous register bus with address, write strobe, read strobe and 16-bit data.

Top module: `pinmux_port`

## Requirements
- R1: While rst_ni is low and after its release, the output-select, enable and input-select registers read 0 and pad_oe_o is all zero. The data-out register also reads 0, and the input-data register reads 0 while all input pins are low.
- R2: With the enable set, pin i drives data-out bit i when select bit i is 0. It drives periph_out_i[i] when select bit i is 1. pad_io carries the same value as pad_o.
- R3: Bit 0 of the enable register (address 2) enables every output pin at once. While it is 0, pad_oe_o is all zero and pad_io floats, whatever the data and select registers hold.
- R4: The register addresses are: 0 data-out (bits 11:0), 1 output-select (bits 11:0), 2 enable (bit 0), 3 input-select (bits 1:0) and 4 input-data (bits 3:0, read-only). Unlisted bits and unused addresses read 0. Writes to address 4 and to unused addresses change nothing.
- R5: uart_txen_o is 0 while input-select bit 0 is 0. While that bit is 1, uart_txen_o follows the synchronized in_pins_i[0].
- R6: uart_rxd_o is 1 while input-select bit 1 is 0. While that bit is 1, uart_rxd_o follows the synchronized in_pins_i[1].
- R7: The input-data register returns the synchronized level of in_pins_i. After a pin changes, the first read that reports the new level is the one captured at the third rising edge; the two reads captured at the earlier edges return the old level. The UART outputs change after the second rising edge.
- R8: A write takes effect at the rising edge where wr_en_i is high. With wr_en_i low, the writable registers keep their values. rdata_o loads on a rising edge with rd_en_i high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| periph_out_i | input | 12 | Peripheral signal per output pin |
| pad_o | output | 12 | Output value per pin |
| pad_oe_o | output | 12 | Output enable per pin |
| pad_io | inout | 12 | Tri-stated pad model |
| in_pins_i | input | 4 | Asynchronous input pins |
| uart_txen_o | output | 1 | Gated UART transmit-enable |
| uart_rxd_o | output | 1 | Gated UART receive data |

## Verification
The bench uses the default parameters: 12 output pins, 4 input pins and a two-stage synchronizer. With 12 of 16 data bits in use, the reserved bits 15:12 are reachable through all-ones writes. The 12-bit width also allows mixed select patterns where software and peripheral values differ on every pin. With two stages, the bench can count the exact edge at which a pin change first shows up in a read, and confirm that the reads captured before it return the old level. It also checks that the UART gating holds its safe levels against pins driven to the opposite value.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT_DATA = 3'd0,
    REG_OUT_SEL  = 3'd1,
    REG_OUT_EN   = 3'd2,
    REG_IN_SEL   = 3'd3,
    REG_IN_DATA  = 3'd4
  } reg_addr_e;

  // input pin roles decoded by the gating logic
  localparam int IN_TXEN = 0;
  localparam int IN_RXD  = 1;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NUM_OUT = 12,
  parameter int NUM_IN  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_IN-1:0]  in_data_i,
  output logic [NUM_OUT-1:0] out_data_o,
  output logic [NUM_OUT-1:0] out_sel_o,
  output logic               out_en_o,
  output logic [1:0]         in_sel_o
);
  logic [NUM_OUT-1:0] out_data_q, out_sel_q;
  logic               out_en_q;
  logic [1:0]         in_sel_q;
  logic [DATA_W-1:0]  rd_val, rdata_q;
  reg_addr_e          addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_data_q <= '0;
      out_sel_q  <= '0;
      out_en_q   <= 1'b0;
      in_sel_q   <= '0;
    end else if (wr_en_i) begin
      case (addr)
        REG_OUT_DATA: out_data_q <= wdata_i[NUM_OUT-1:0];
        REG_OUT_SEL:  out_sel_q  <= wdata_i[NUM_OUT-1:0];
        REG_OUT_EN:   out_en_q   <= wdata_i[0];
        REG_IN_SEL:   in_sel_q   <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      REG_OUT_DATA: rd_val[NUM_OUT-1:0] = out_data_q;
      REG_OUT_SEL:  rd_val[NUM_OUT-1:0] = out_sel_q;
      REG_OUT_EN:   rd_val[0]           = out_en_q;
      REG_IN_SEL:   rd_val[1:0]         = in_sel_q;
      REG_IN_DATA:  rd_val[NUM_IN-1:0]  = in_data_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o    = rdata_q;
  assign out_data_o = out_data_q;
  assign out_sel_o  = out_sel_q;
  assign out_en_o   = out_en_q;
  assign in_sel_o   = in_sel_q;
endmodule

// File: rtl/pinmux_out_stage.sv
module pinmux_out_stage #(
  parameter int NUM_OUT = 12
) (
  input  logic [NUM_OUT-1:0] out_data_i,
  input  logic [NUM_OUT-1:0] out_sel_i,
  input  logic               out_en_i,
  input  logic [NUM_OUT-1:0] periph_out_i,
  output logic [NUM_OUT-1:0] pad_o,
  output logic [NUM_OUT-1:0] pad_oe_o
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
    assign pad_o[i]    = out_sel_i[i] ? periph_out_i[i] : out_data_i[i];
    assign pad_oe_o[i] = out_en_i;
  end
endmodule

// File: rtl/pinmux_in_stage.sv
module pinmux_in_stage
  import pinmux_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] in_pins_i,
  input  logic [1:0]        in_sel_i,
  output logic [NUM_IN-1:0] in_sync_o,
  output logic              uart_txen_o,
  output logic              uart_rxd_o
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[SYNC_STAGES-2:0], in_pins_i[i]};
    end
    assign in_sync_o[i] = chain_q[SYNC_STAGES-1];
  end

  // deselected UART inputs see their idle levels
  assign uart_txen_o = in_sel_i[0] & in_sync_o[IN_TXEN];
  assign uart_rxd_o  = ~in_sel_i[1] | in_sync_o[IN_RXD];
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int NUM_OUT     = 12,
  parameter int NUM_IN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_OUT-1:0] periph_out_i,
  output logic [NUM_OUT-1:0] pad_o,
  output logic [NUM_OUT-1:0] pad_oe_o,
  inout  wire  [NUM_OUT-1:0] pad_io,
  input  logic [NUM_IN-1:0]  in_pins_i,
  output logic               uart_txen_o,
  output logic               uart_rxd_o
);
  logic [NUM_OUT-1:0] out_data, out_sel;
  logic               out_en;
  logic [1:0]         in_sel;
  logic [NUM_IN-1:0]  in_sync;

  pinmux_regs #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .rd_en_i    (rd_en_i),
    .rdata_o    (rdata_o),
    .in_data_i  (in_sync),
    .out_data_o (out_data),
    .out_sel_o  (out_sel),
    .out_en_o   (out_en),
    .in_sel_o   (in_sel)
  );

  pinmux_out_stage #(.NUM_OUT(NUM_OUT)) i_out (
    .out_data_i   (out_data),
    .out_sel_i    (out_sel),
    .out_en_i     (out_en),
    .periph_out_i (periph_out_i),
    .pad_o        (pad_o),
    .pad_oe_o     (pad_oe_o)
  );

  pinmux_in_stage #(.NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES)) i_in (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_pins_i   (in_pins_i),
    .in_sel_i    (in_sel),
    .in_sync_o   (in_sync),
    .uart_txen_o (uart_txen_o),
    .uart_rxd_o  (uart_rxd_o)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pad
    assign pad_io[i] = pad_oe_o[i] ? pad_o[i] : 1'bz;
  end
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk #(
  parameter int NUM_OUT = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [NUM_OUT-1:0] out_data,
  input logic [NUM_OUT-1:0] out_sel,
  input logic               out_en,
  input logic [1:0]         in_sel,
  input logic [NUM_OUT-1:0] periph_out_i,
  input logic [NUM_OUT-1:0] pad_o,
  input logic [NUM_OUT-1:0] pad_oe_o,
  input logic               uart_txen_o,
  input logic               uart_rxd_o
);
  AST_OE_ALL_OR_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o == '0) || (pad_oe_o == '1)); // R3
  AST_OE_FOLLOWS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en |-> (pad_oe_o == '0)); // R3
  AST_PORT_MODE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o ^ out_data) & ~out_sel) == '0); // R2
  AST_PERIPH_MODE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o ^ periph_out_i) & out_sel) == '0); // R2
  AST_TXEN_FORCED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_sel[0] |-> !uart_txen_o); // R5
  AST_RXD_FORCED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_sel[1] |-> uart_rxd_o); // R6
  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(out_sel) && $stable(out_data) && $stable(out_en) && $stable(in_sel))); // R8
endmodule

bind pinmux_port pinmux_port_chk #(.NUM_OUT(NUM_OUT)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .out_data     (out_data),
  .out_sel      (out_sel),
  .out_en       (out_en),
  .in_sel       (in_sel),
  .periph_out_i (periph_out_i),
  .pad_o        (pad_o),
  .pad_oe_o     (pad_oe_o),
  .uart_txen_o  (uart_txen_o),
  .uart_rxd_o   (uart_rxd_o)
);

// File: tb/test_pinmux_port.sv
module test_pinmux_port;
  localparam int NO = 12;
  localparam int NI = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    addr_i = '0;
  logic          wr_en_i = 1'b0;
  logic [15:0]   wdata_i = '0;
  logic          rd_en_i = 1'b0;
  logic [15:0]   rdata_o;
  logic [NO-1:0] periph_out_i = '0;
  logic [NO-1:0] pad_o, pad_oe_o;
  wire  [NO-1:0] pad_io;
  logic [NI-1:0] in_pins_i = '0;
  logic          uart_txen_o, uart_rxd_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        fire_q = 1'b0;

  always #10 clk_i = ~clk_i;

  pinmux_port i_pinmux_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .periph_out_i(periph_out_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
    .pad_io(pad_io), .in_pins_i(in_pins_i),
    .uart_txen_o(uart_txen_o), .uart_rxd_o(uart_rxd_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver tasks: called at a falling edge, return at the next one
  task automatic wr(logic [2:0] a, logic [15:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [15:0] exp, string req);
    addr_i = a; rd_en_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  // monitor: compares read data one edge after each strobe
  always @(posedge clk_i) fire_q <= rd_en_i;
  always @(negedge clk_i) begin
    if (fire_q) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R8 unexpected read actual=%h expected=none", rdata_o);
      end else begin
        chk(tag_q.pop_front(), {16'h0, rdata_o}, {16'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic chk_pads(string req, logic en, logic [NO-1:0] data, logic [NO-1:0] sel);
    logic [NO-1:0] exp;
    exp = (sel & periph_out_i) | (~sel & data);
    chk({req, " oe"}, {20'h0, pad_oe_o}, en ? {20'h0, {NO{1'b1}}} : 32'h0);
    if (en) begin
      chk({req, " pad_o"}, {20'h0, pad_o}, {20'h0, exp});
      chk({req, " pad_io"}, {20'h0, pad_io}, {20'h0, exp});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 oe in reset", {20'h0, pad_oe_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(3'd0, 16'h0000, "R1 data-out reset");
    rd(3'd1, 16'h0000, "R1 select reset");
    rd(3'd2, 16'h0000, "R1 enable reset");
    rd(3'd3, 16'h0000, "R1 input-select reset");
    rd(3'd4, 16'h0000, "R1 input-data reset");
    chk("R1 oe after reset", {20'h0, pad_oe_o}, 32'h0);

    // R4 reserved bits and register map
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h0FFF, "R4 data-out reserved bits");
    wr(3'd0, 16'h0A5C);
    rd(3'd0, 16'h0A5C, "R8 data-out write");
    rd(3'd6, 16'h0000, "R4 unused address");
    wr(3'd6, 16'hFFFF);
    rd(3'd1, 16'h0000, "R4 unused address write ignored");

    // R3 disabled drivers despite data
    periph_out_i = 12'h3C3;
    @(negedge clk_i);
    chk_pads("R3 disabled", 1'b0, 12'hA5C, 12'h000);

    wr(3'd2, 16'hFFFF);
    rd(3'd2, 16'h0001, "R4 enable reserved bits");
    chk_pads("R2 port mode", 1'b1, 12'hA5C, 12'h000);

    wr(3'd1, 16'hF0F0);
    rd(3'd1, 16'h00F0, "R4 select reserved bits");
    chk_pads("R2 mixed select", 1'b1, 12'hA5C, 12'h0F0);
    periph_out_i = 12'h81F;
    #1;
    chk_pads("R2 peripheral change", 1'b1, 12'hA5C, 12'h0F0);
    wr(3'd1, 16'h0FFF);
    chk_pads("R2 all peripheral", 1'b1, 12'hA5C, 12'hFFF);
    wr(3'd1, 16'h0555);
    chk_pads("R2 alternating select", 1'b1, 12'hA5C, 12'h555);

    wr(3'd2, 16'h0002);
    rd(3'd2, 16'h0000, "R3 enable bit0 clear");
    chk_pads("R3 disable all", 1'b0, 12'hA5C, 12'h555);

    // R5/R6 gating with pins opposite to idle
    in_pins_i = 4'b0001;
    repeat (3) @(negedge clk_i);
    chk("R5 txen forced low", {31'h0, uart_txen_o}, 32'h0);
    chk("R6 rxd forced high", {31'h0, uart_rxd_o}, 32'h1);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, 16'h0003, "R4 input-select reserved bits");
    chk("R5 txen follows pin", {31'h0, uart_txen_o}, 32'h1);
    chk("R6 rxd follows pin", {31'h0, uart_rxd_o}, 32'h0);

    // R4 write to input-data ignored
    wr(3'd4, 16'hFFFF);
    rd(3'd4, 16'h0001, "R4 input-data read-only");

    // R7 latency: reads captured at edges 1,2 old, edge 3 new
    in_pins_i = 4'b1010;
    rd(3'd4, 16'h0001, "R7 first edge old");
    rd(3'd4, 16'h0001, "R7 second edge old");
    chk("R7 txen after two edges", {31'h0, uart_txen_o}, 32'h0);
    chk("R7 rxd after two edges", {31'h0, uart_rxd_o}, 32'h1);
    rd(3'd4, 16'h000A, "R7 third edge new");
    in_pins_i = 4'b0101;
    repeat (2) @(negedge clk_i);
    rd(3'd4, 16'h0005, "R7 second pattern");
    rd(3'd2, 16'h0000, "R8 enable held");
    @(negedge clk_i);
    chk("R8 read data holds", {16'h0, rdata_o}, 32'h0);
    @(negedge clk_i);
    chk("R8 scoreboard drained", exp_q.size(), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule